// File: doc/BRIEF.md
# Blocked-Access Response and Capture Unit

This unit sits inside a memory protection controller, behind the stage that has already decided an access must not reach memory. Each such access arrives as a one-cycle request. The unit answers it on the next cycle. The answer is either a bus error or a normal completion that reads as zero and discards write data. Which of the two is used depends on one control bit.

The unit also keeps a record for software. The first refused access after the interrupt status was cleared has its address and its attributes latched into two info registers. The attributes are the requester identity, whether the access was non-secure, and the security bit the per-block lookup table holds for the target block. Every later refusal is still answered, but it leaves the record untouched until software clears the status. An interrupt line reports the status through an enable. The lookup table, the control bit, the status, the enable and the info words are all reached through a small 32-bit register port.

Top module: `blkacc_handler`

## Requirements
- R1: A refused access, read or write, completes with response data of zero, and its write data reaches nothing.
- R2: The response comes one cycle after the request (`rsp_valid` high for one cycle). `rsp_err` equals bit 0 of the control register at offset 0x00 as it stood when the request was taken.
- R3: A refused access is captured only while the status bit is 0. While the status is 1, the info registers keep their values.
- R4: On capture, the info register at 0x2C holds the byte address of the access, zero-extended. Writes to 0x2C and 0x30 are ignored.
- R5: On capture, the info register at 0x30 holds the requester ID's low 16 bits in bits 15:0, 1 in bit 16 for a non-secure access, and the lookup-table bit of the accessed block in bit 17. Bits 31:18 are 0.
- R6: The table bit of an address is bit (block mod 32) of table word (block div 32), where block = address div BLK_BYTES. Software selects a word by writing its index to 0x10. It then reads or writes that word at 0x14.
- R7: A capture sets the status bit, which reads back at 0x20 bit 0. `irq` is 1 exactly when the status and the enable (0x28 bit 0) are both 1.
- R8: Writing 1 to bit 0 of 0x24 clears the status, and writing 1 to bit 0 of 0x34 sets it. A capture in the same cycle as a clear leaves the status set.
- R9: After reset every register, the table, `irq`, `rsp_valid` and `reg_rvalid` are 0.
- R10: A register read returns its data one cycle after the request, with `reg_rvalid` high. Write-only and unmapped offsets read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| acc_req | input | 1 | One-cycle request for a refused access |
| acc_addr | input | ADDR_W | Byte address within the protected region |
| acc_write | input | 1 | Access is a write |
| acc_secure | input | 1 | Access carries the secure attribute |
| acc_id | input | ID_W | Requester identity |
| rsp_valid | output | 1 | Response strobe, one cycle after the request |
| rsp_err | output | 1 | Bus error response |
| rsp_rdata | output | DATA_W | Response read data (always zero) |
| reg_req | input | 1 | Register port request |
| reg_write | input | 1 | Register port write |
| reg_addr | input | 8 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rvalid | output | 1 | Register read data strobe |
| reg_rdata | output | 32 | Register read data |
| irq | output | 1 | Interrupt request |

## Verification
Wrong capture gating in the status bit shows at the next read of 0x2C or 0x30, because a second refusal overwrites the first record. A wrong lookup-table index shows as a wrong bit 17 in that same word. A stale control bit shows on `rsp_err` in the response cycle of the very next refused access. The status/enable state drives `irq` directly, so a missed set, clear or clear/capture race shows on `irq` in the cycle after the register write or the access.

// File: rtl/blkacc_pkg.sv
package blkacc_pkg;
    localparam int REG_AW = 8;
    localparam int REG_DW = 32;
    localparam int INFO2_W = 18;

    localparam logic [REG_AW-1:0] OFS_CTRL  = 8'h00;
    localparam logic [REG_AW-1:0] OFS_LIDX  = 8'h10;
    localparam logic [REG_AW-1:0] OFS_LDATA = 8'h14;
    localparam logic [REG_AW-1:0] OFS_STAT  = 8'h20;
    localparam logic [REG_AW-1:0] OFS_CLR   = 8'h24;
    localparam logic [REG_AW-1:0] OFS_EN    = 8'h28;
    localparam logic [REG_AW-1:0] OFS_INFO1 = 8'h2C;
    localparam logic [REG_AW-1:0] OFS_INFO2 = 8'h30;
    localparam logic [REG_AW-1:0] OFS_SET   = 8'h34;

    typedef struct packed {
        logic                err_resp;
        logic                status;
        logic                irq_en;
        logic [REG_DW-1:0]   info1;
        logic [INFO2_W-1:0]  info2;
    } cap_state_t;
endpackage

// File: rtl/blkacc_lut.sv
module blkacc_lut #(
    parameter int ADDR_W    = 16,
    parameter int BLK_BYTES = 32,
    localparam int BLK_SH   = $clog2(BLK_BYTES),
    localparam int NBLK_W   = ADDR_W - BLK_SH,
    localparam int WIDX_W   = NBLK_W - 5,
    localparam int NWORDS   = 1 << WIDX_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [WIDX_W-1:0] wr_idx,
    input  logic [31:0]       wr_data,
    input  logic [WIDX_W-1:0] rd_idx,
    output logic [31:0]       rd_data,
    input  logic [ADDR_W-1:0] look_addr,
    output logic              look_bit
);
    logic [NWORDS-1:0][31:0] lut_d, lut_q;
    logic [NBLK_W-1:0]       blk_num;
    logic [WIDX_W-1:0]       blk_word;
    logic [4:0]              blk_bit;

    always_comb begin
        lut_d = lut_q;
        if (wr_en) lut_d[wr_idx] = wr_data;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lut_q <= '0;
        else        lut_q <= lut_d;
    end

    always_comb begin
        blk_num  = look_addr[ADDR_W-1:BLK_SH];
        blk_word = blk_num[NBLK_W-1:5];
        blk_bit  = blk_num[4:0];
        look_bit = lut_q[blk_word][blk_bit];
        rd_data  = lut_q[rd_idx];
    end

    // R6: a table write is visible in the addressed word next cycle
    p_write_lands_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> lut_q[$past(wr_idx)] == $past(wr_data));
endmodule

// File: rtl/blkacc_capture.sv
module blkacc_capture
    import blkacc_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_secure,
    input  logic [15:0]       acc_id16,
    input  logic              acc_lut_bit,
    input  logic              sw_ctrl_we,
    input  logic              sw_ctrl_bit,
    input  logic              sw_en_we,
    input  logic              sw_en_bit,
    input  logic              sw_clr,
    input  logic              sw_set,
    output cap_state_t        st_q,
    output logic              irq
);
    cap_state_t st_d;
    logic       capture;

    always_comb begin
        st_d    = st_q;
        capture = acc_req && !st_q.status;
        if (sw_ctrl_we) st_d.err_resp = sw_ctrl_bit;
        if (sw_en_we)   st_d.irq_en   = sw_en_bit;
        if (sw_clr)     st_d.status   = 1'b0;
        if (sw_set)     st_d.status   = 1'b1;
        if (capture) begin
            st_d.status               = 1'b1;
            st_d.info1                = '0;
            st_d.info1[ADDR_W-1:0]    = acc_addr;
            st_d.info2                = {acc_lut_bit, ~acc_secure, acc_id16};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign irq = st_q.status && st_q.irq_en;

    // R3: a held status freezes the record
    p_info_frozen_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.status |=> $stable(st_q.info1) && $stable(st_q.info2));
    // R7: a refused access with status clear leaves status set
    p_capture_sets_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && !st_q.status) |=> st_q.status);
    // R8: a lone clear drops the status
    p_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (sw_clr && !sw_set && !(acc_req && !st_q.status)) |=> !st_q.status);
endmodule

// File: rtl/blkacc_handler.sv
module blkacc_handler
    import blkacc_pkg::*;
#(
    parameter int ADDR_W    = 16,
    parameter int BLK_BYTES = 32,
    parameter int ID_W      = 16,
    parameter int DATA_W    = 32,
    localparam int BLK_SH   = $clog2(BLK_BYTES),
    localparam int WIDX_W   = ADDR_W - BLK_SH - 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_req,
    input  logic [ADDR_W-1:0] acc_addr,
    input  logic              acc_write,
    input  logic              acc_secure,
    input  logic [ID_W-1:0]   acc_id,
    output logic              rsp_valid,
    output logic              rsp_err,
    output logic [DATA_W-1:0] rsp_rdata,
    input  logic              reg_req,
    input  logic              reg_write,
    input  logic [7:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              reg_rvalid,
    output logic [31:0]       reg_rdata,
    output logic              irq
);
    typedef struct packed {
        logic              rsp_valid;
        logic              rsp_err;
        logic              reg_rvalid;
        logic [31:0]       reg_rdata;
        logic [WIDX_W-1:0] lut_idx;
    } top_state_t;

    top_state_t  t_d, t_q;
    cap_state_t  cap_q;
    logic        sw_wr;
    logic        lut_we, lut_bit;
    logic [31:0] lut_rd;

    always_comb sw_wr = reg_req && reg_write;
    always_comb lut_we = sw_wr && (reg_addr == OFS_LDATA);

    blkacc_lut #(.ADDR_W(ADDR_W), .BLK_BYTES(BLK_BYTES)) i_lut (
        .clk(clk), .rst_n(rst_n),
        .wr_en(lut_we), .wr_idx(t_q.lut_idx), .wr_data(reg_wdata),
        .rd_idx(t_q.lut_idx), .rd_data(lut_rd),
        .look_addr(acc_addr), .look_bit(lut_bit)
    );

    blkacc_capture #(.ADDR_W(ADDR_W)) i_capture (
        .clk(clk), .rst_n(rst_n),
        .acc_req(acc_req), .acc_addr(acc_addr), .acc_secure(acc_secure),
        .acc_id16(acc_id[15:0]), .acc_lut_bit(lut_bit),
        .sw_ctrl_we(sw_wr && reg_addr == OFS_CTRL), .sw_ctrl_bit(reg_wdata[0]),
        .sw_en_we(sw_wr && reg_addr == OFS_EN),     .sw_en_bit(reg_wdata[0]),
        .sw_clr(sw_wr && reg_addr == OFS_CLR && reg_wdata[0]),
        .sw_set(sw_wr && reg_addr == OFS_SET && reg_wdata[0]),
        .st_q(cap_q), .irq(irq)
    );

    always_comb begin
        t_d            = t_q;
        t_d.rsp_valid  = acc_req;
        t_d.rsp_err    = acc_req && cap_q.err_resp;
        t_d.reg_rvalid = reg_req && !reg_write;
        t_d.reg_rdata  = '0;
        if (sw_wr && reg_addr == OFS_LIDX) t_d.lut_idx = reg_wdata[WIDX_W-1:0];
        if (reg_req && !reg_write) begin
            case (reg_addr)
                OFS_CTRL:  t_d.reg_rdata = {31'b0, cap_q.err_resp};
                OFS_LIDX:  t_d.reg_rdata = 32'(t_q.lut_idx);
                OFS_LDATA: t_d.reg_rdata = lut_rd;
                OFS_STAT:  t_d.reg_rdata = {31'b0, cap_q.status};
                OFS_EN:    t_d.reg_rdata = {31'b0, cap_q.irq_en};
                OFS_INFO1: t_d.reg_rdata = cap_q.info1;
                OFS_INFO2: t_d.reg_rdata = 32'(cap_q.info2);
                default:   t_d.reg_rdata = '0;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) t_q <= '0;
        else        t_q <= t_d;
    end

    assign rsp_valid  = t_q.rsp_valid;
    assign rsp_err    = t_q.rsp_err;
    assign rsp_rdata  = '0;
    assign reg_rvalid = t_q.reg_rvalid;
    assign reg_rdata  = t_q.reg_rdata;

    // R2: every request is answered next cycle with the control bit's choice
    p_rsp_timing_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_req |=> rsp_valid && (rsp_err == $past(cap_q.err_resp)));
    // R1: a refused write returns zero data
    p_write_zero_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (acc_req && acc_write) |=> rsp_rdata == '0);
    // R10: read data strobe follows a read request
    p_read_strobe_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_req && !reg_write) |=> reg_rvalid);
endmodule

// File: tb/test_blkacc_handler.sv
`timescale 1ns/1ps
module test_blkacc_handler;
    logic        clk = 0, rst_n = 0;
    logic        acc_req = 0, acc_write = 0, acc_secure = 0;
    logic [15:0] acc_addr = 0, acc_id = 0;
    logic        rsp_valid, rsp_err, reg_rvalid, irq;
    logic [31:0] rsp_rdata, reg_rdata;
    logic        reg_req = 0, reg_write = 0;
    logic [7:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;

    int errors = 0, checks = 0;
    logic [32:0] exp_rsp_q[$];  string rsp_tag_q[$];
    logic [31:0] exp_reg_q[$];  string reg_tag_q[$];

    logic        m_ctrl = 0, m_status = 0, m_en = 0;
    logic [5:0]  m_lidx = 0;
    logic [31:0] m_info1 = 0, m_info2 = 0;
    logic [31:0] m_lut [64];

    always #10 clk = ~clk;

    blkacc_handler i_blkacc_handler (
        .clk(clk), .rst_n(rst_n), .acc_req(acc_req), .acc_addr(acc_addr),
        .acc_write(acc_write), .acc_secure(acc_secure), .acc_id(acc_id),
        .rsp_valid(rsp_valid), .rsp_err(rsp_err), .rsp_rdata(rsp_rdata),
        .reg_req(reg_req), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rvalid(reg_rvalid), .reg_rdata(reg_rdata),
        .irq(irq)
    );

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (rsp_valid) begin
            if (exp_rsp_q.size() == 0) chk("R2 unexpected response", 1, 0);
            else chk(rsp_tag_q.pop_front(), {31'b0, rsp_err, rsp_rdata}, 64'(exp_rsp_q.pop_front()));
        end
        if (reg_rvalid) begin
            if (exp_reg_q.size() == 0) chk("R10 unexpected read data", 1, 0);
            else chk(reg_tag_q.pop_front(), 64'(reg_rdata), 64'(exp_reg_q.pop_front()));
        end
    end

    function automatic logic lut_bit(input logic [15:0] a);
        int blk = int'(a) / 32;
        return m_lut[blk / 32][blk % 32];
    endfunction

    function automatic logic [31:0] exp_read(input logic [7:0] a);
        case (a)
            8'h00: return {31'b0, m_ctrl};
            8'h10: return 32'(m_lidx);
            8'h14: return m_lut[m_lidx];
            8'h20: return {31'b0, m_status};
            8'h28: return {31'b0, m_en};
            8'h2C: return m_info1;
            8'h30: return m_info2;
            default: return 32'h0;
        endcase
    endfunction

    task automatic model_wr(input logic [7:0] a, input logic [31:0] d);
        case (a)
            8'h00: m_ctrl = d[0];
            8'h10: m_lidx = d[5:0];
            8'h14: m_lut[m_lidx] = d;
            8'h24: if (d[0]) m_status = 0;
            8'h28: m_en = d[0];
            8'h34: if (d[0]) m_status = 1;
            default: ;
        endcase
    endtask

    task automatic model_acc(input logic cap, input logic [15:0] a, input logic sec, input logic [15:0] id);
        if (cap) begin
            m_status = 1;
            m_info1  = 32'(a);
            m_info2  = {14'b0, lut_bit(a), ~sec, id};
        end
    endtask

    task automatic reg_wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        reg_req = 1; reg_write = 1; reg_addr = a; reg_wdata = d;
        @(posedge clk); #1;
        reg_req = 0; reg_write = 0;
        model_wr(a, d);
    endtask

    task automatic reg_rd(input logic [7:0] a, input string tag);
        exp_reg_q.push_back(exp_read(a)); reg_tag_q.push_back(tag);
        @(posedge clk); #1;
        reg_req = 1; reg_write = 0; reg_addr = a;
        @(posedge clk); #1;
        reg_req = 0;
    endtask

    task automatic acc(input logic [15:0] a, input logic wr, input logic sec,
                       input logic [15:0] id, input string tag);
        logic cap = !m_status;
        exp_rsp_q.push_back({m_ctrl, 32'h0}); rsp_tag_q.push_back(tag);
        @(posedge clk); #1;
        acc_req = 1; acc_addr = a; acc_write = wr; acc_secure = sec; acc_id = id;
        @(posedge clk); #1;
        acc_req = 0;
        model_acc(cap, a, sec, id);
    endtask

    task automatic acc_with_wr(input logic [15:0] a, input logic sec, input logic [15:0] id,
                               input logic [7:0] ra, input logic [31:0] rd, input string tag);
        logic cap = !m_status;
        exp_rsp_q.push_back({m_ctrl, 32'h0}); rsp_tag_q.push_back(tag);
        @(posedge clk); #1;
        acc_req = 1; acc_addr = a; acc_write = 0; acc_secure = sec; acc_id = id;
        reg_req = 1; reg_write = 1; reg_addr = ra; reg_wdata = rd;
        @(posedge clk); #1;
        acc_req = 0; reg_req = 0; reg_write = 0;
        model_wr(ra, rd);
        model_acc(cap, a, sec, id);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++; checks++;
        $display("FAIL all: watchdog expired actual=hung expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 64; i++) m_lut[i] = 0;
        repeat (3) @(posedge clk); #1;
        rst_n = 1;
        // R9 reset state
        chk("R9 irq after reset", 64'(irq), 0);
        chk("R9 rsp_valid after reset", 64'(rsp_valid), 0);
        chk("R9 reg_rvalid after reset", 64'(reg_rvalid), 0);
        reg_rd(8'h00, "R9 ctrl reset");
        reg_rd(8'h20, "R9 status reset");
        reg_rd(8'h28, "R9 enable reset");
        reg_rd(8'h2C, "R9 info1 reset");
        reg_rd(8'h30, "R9 info2 reset");
        reg_wr(8'h10, 32'd9);
        reg_rd(8'h14, "R9 table word reset");
        // R6 table access: 0x1234 is block 145, word 4, bit 17
        reg_wr(8'h10, 32'd4);
        reg_wr(8'h14, 32'h0002_0000);
        reg_rd(8'h10, "R6 index readback");
        reg_rd(8'h14, "R6 table word readback");
        reg_wr(8'h28, 32'd1);
        // R1 R2 refused read with OK response; R5 table bit set, secure
        acc(16'h1234, 0, 1, 16'hABCD, "R1 R2 read OK response zero data");
        chk("R7 irq after capture", 64'(irq), 1);
        reg_rd(8'h20, "R7 status set");
        reg_rd(8'h2C, "R4 info1 address");
        reg_rd(8'h30, "R5 info2 fields secure");
        // R3 second refusal leaves the record
        acc(16'h0040, 1, 0, 16'h1111, "R1 write OK response");
        reg_rd(8'h2C, "R3 info1 frozen");
        reg_rd(8'h30, "R3 info2 frozen");
        // R4 info registers ignore writes
        reg_wr(8'h2C, 32'hFFFF_FFFF);
        reg_wr(8'h30, 32'hFFFF_FFFF);
        reg_rd(8'h2C, "R4 info1 write ignored");
        reg_rd(8'h30, "R4 info2 write ignored");
        // R8 clear
        reg_wr(8'h24, 32'd1);
        chk("R8 irq after clear", 64'(irq), 0);
        reg_rd(8'h20, "R8 status cleared");
        // R2 error response, non-secure, table bit clear
        reg_wr(8'h00, 32'd1);
        reg_rd(8'h00, "R2 ctrl readback");
        acc(16'h0044, 1, 0, 16'h5555, "R2 error response");
        reg_rd(8'h2C, "R4 info1 second capture");
        reg_rd(8'h30, "R5 info2 non-secure");
        // R7 enable gates irq
        reg_wr(8'h28, 32'd0);
        chk("R7 irq masked", 64'(irq), 0);
        reg_wr(8'h28, 32'd1);
        chk("R7 irq unmasked", 64'(irq), 1);
        // R8 clear and capture in same cycle: capture wins
        reg_wr(8'h24, 32'd1);
        acc_with_wr(16'h0800, 1, 16'h0077, 8'h24, 32'd1, "R2 error with clear race");
        chk("R8 irq capture beats clear", 64'(irq), 1);
        reg_rd(8'h20, "R8 status capture beats clear");
        reg_rd(8'h2C, "R8 info1 from raced capture");
        // R8 set forces status without capture; R3 later access not captured
        reg_wr(8'h24, 32'd1);
        reg_wr(8'h34, 32'd1);
        chk("R8 irq after set", 64'(irq), 1);
        reg_rd(8'h20, "R8 status after set");
        reg_wr(8'h00, 32'd0);
        acc(16'h0100, 0, 1, 16'h2222, "R2 OK response after set");
        reg_rd(8'h2C, "R3 info1 unchanged after set");
        // R6 top block: 0xFFE0 is block 2047, word 63, bit 31
        reg_wr(8'h10, 32'd63);
        reg_wr(8'h14, 32'h8000_0000);
        reg_wr(8'h24, 32'd1);
        acc(16'hFFE0, 0, 0, 16'hBEEF, "R1 read top block");
        reg_rd(8'h30, "R6 info2 top table bit");
        reg_rd(8'h2C, "R4 info1 top address");
        // R10 write-only and unmapped offsets
        reg_rd(8'h24, "R10 clear reads zero");
        reg_rd(8'h34, "R10 set reads zero");
        reg_rd(8'h3C, "R10 unmapped reads zero");
        repeat (3) @(posedge clk); #1;
        chk("R2 responses all seen", 64'(exp_rsp_q.size()), 0);
        chk("R10 reads all seen", 64'(exp_reg_q.size()), 0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule